// File: doc/BRIEF.md
# Fractional Clock-Enable Generator with Commit Handshake

This block drives a single-cycle enable strobe at an average rate of the input clock times `mult/32`, where `mult` ranges from 1 to 32. Logic downstream uses the strobe as a clock enable, so it can run at a lower effective rate without a second clock. The rate is held as an inverted 5-bit code: `mult = 32 - code`. A code of zero therefore means full rate.

Software works through two 32-bit registers on a simple write/read port. It first places a new code in the control register, which updates only a shadow copy. It then sets the commit bit in a second register. The hardware copies the shadow code into the active copy at the next 32-cycle frame boundary and clears the commit bit itself. That clear tells software the new rate is running. While a commit is pending, further code writes are dropped and the `rate_busy` output is high.

The strobes are spread evenly across each frame by a 5-bit phase accumulator. It adds `mult` every cycle and fires on a carry out of 32. Because the accumulator is back at zero at every frame start, each frame holds exactly `mult` strobes.

Top module: `frac_clken_gen`

## Requirements
- R1: After a synchronous active-low reset, the code and the commit bit are 0, `rate_busy` is 0 and `clk_en` is 0. Once reset is released, `clk_en` is high on every cycle (32/32).
- R2: The control register sits at byte offset 0x0, with the code at bits 12:8. A write there changes only bits 12:8. All other bits of that register read as 0 whatever value was written.
- R3: Writing a new code without a commit does not change the strobe rate on `clk_en`.
- R4: The commit register sits at byte offset 0x4, with the commit bit at bit 31. Writing a 1 to bit 31 sets it, and it reads back as 1, with `rate_busy` high, until the commit completes. A write with bit 31 at 0 leaves it at 0.
- R5: A set commit bit clears by itself no later than 34 cycles after the write that set it.
- R6: Once the commit bit has cleared, every 32-cycle window of `clk_en` holds exactly `32 - code` strobes.
- R7: While the commit bit is set, writes to the control register are ignored. The code read back and the rate applied after the commit are the values from before those writes.
- R8: Strobes are evenly spread. In steady state, the gap between consecutive strobes is floor(32/mult) or ceil(32/mult) cycles.
- R9: The active rate changes only at a frame boundary. The phase accumulator is 0 at the start of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rate_busy | output | 1 | High while a commit is pending |
| clk_en | output | 1 | Registered clock-enable strobe |

## Verification
Register writes are captured on the rising edge after they are driven. A read of the code or the commit bit is valid from the following falling edge, because read data is combinational. A commit lands on the edge where the frame counter is at its last count. The commit bit is read as cleared one half-cycle later, and the bench polls it each cycle against a bound of 34. `clk_en` is registered, so strobes under a new rate appear starting one cycle after the commit. The bench therefore waits one cycle after seeing the bit clear before it counts strobes over 32-cycle windows. It also records strobe gaps over 64 cycles so that uneven spreading is caught.

// File: rtl/frac_clken_pkg.sv
// Package: shared constants and helpers for the fractional clock-enable
// generator. Assumes a power-of-two frame of 2**ACC_W cycles.
package frac_clken_pkg;
    localparam int unsigned BUS_W = 32;

    // Convert an inverted rate code to a multiplier in 1..2**acc_w.
    function automatic int unsigned code_to_mult(input int unsigned code, input int unsigned acc_w);
        return (1 << acc_w) - code;
    endfunction
endpackage

// File: rtl/frac_clken_regs.sv
// Module: register file holding the shadow rate code and the commit bit.
// Assumes commit is only asserted while pending is high.
module frac_clken_regs #(
    parameter int unsigned ACC_W     = 5,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned FIELD_LSB = 8,
    parameter int unsigned KICK_BIT  = 31,
    parameter int unsigned CTRL_OFS  = 0,
    parameter int unsigned KICK_OFS  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [frac_clken_pkg::BUS_W-1:0]  bus_wdata,
    input  logic                              commit,
    output logic [ACC_W-1:0]                  shadow_code,
    output logic                              pending,
    output logic [frac_clken_pkg::BUS_W-1:0]  bus_rdata
);
    import frac_clken_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(KICK_OFS);

    logic hit_ctrl;
    logic hit_kick;

    // Decode which register a write targets.
    always_comb begin
        hit_ctrl = bus_wr && (bus_addr == CTRL_A);
        hit_kick = bus_wr && (bus_addr == KICK_A);
    end

    // Shadow code: field-only update, blocked while a commit is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_code <= '0;
        end else if (hit_ctrl && !pending) begin
            shadow_code <= bus_wdata[FIELD_LSB +: ACC_W];
        end
    end

    // Commit bit: set by software, cleared by hardware on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (commit) begin
            pending <= 1'b0;
        end else if (hit_kick && bus_wdata[KICK_BIT]) begin
            pending <= 1'b1;
        end
    end

    // Read mux: unused bits read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_A) begin
            bus_rdata[FIELD_LSB +: ACC_W] = shadow_code;
        end else if (bus_addr == KICK_A) begin
            bus_rdata[KICK_BIT] = pending;
        end
    end
endmodule

// File: rtl/frac_clken_frame.sv
// Module: frame counter and commit point. Copies the shadow code into the
// active code on the last cycle of a frame when a commit is pending.
// Assumes the frame length is 2**ACC_W.
module frac_clken_frame #(
    parameter int unsigned ACC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic [ACC_W-1:0] shadow_code,
    output logic [ACC_W-1:0] frame_cnt,
    output logic             commit,
    output logic [ACC_W-1:0] active_code
);
    localparam logic [ACC_W-1:0] LAST = '1;

    // Commit fires on the frame's final cycle only.
    always_comb begin
        commit = pending && (frame_cnt == LAST);
    end

    // Free-running frame position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
        end else begin
            frame_cnt <= frame_cnt + 1'b1;
        end
    end

    // Active code loads from shadow at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_code <= '0;
        end else if (commit) begin
            active_code <= shadow_code;
        end
    end
endmodule

// File: rtl/frac_clken_phase.sv
// Module: phase accumulator. Adds mult each cycle modulo 2**ACC_W and
// emits a registered strobe on each carry. Assumes mult is in 1..2**ACC_W.
module frac_clken_phase #(
    parameter int unsigned ACC_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [ACC_W:0] mult,
    output logic [ACC_W-1:0] acc,
    output logic           strobe
);
    logic [ACC_W+1:0] sum;

    // Next phase sum with room for the carry.
    always_comb begin
        sum = {1'b0, acc} + {1'b0, mult};
    end

    // Phase register and registered carry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            strobe <= 1'b0;
        end else begin
            acc    <= sum[ACC_W-1:0];
            strobe <= |sum[ACC_W+1:ACC_W];
        end
    end
endmodule

// File: rtl/frac_clken_gen.sv
// Module: top of the fractional clock-enable generator. Ties the register
// file, frame sequencer and phase accumulator together. Assumes a single
// clock domain and synchronous active-low reset.
module frac_clken_gen #(
    parameter int unsigned ACC_W     = 5,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned FIELD_LSB = 8,
    parameter int unsigned KICK_BIT  = 31,
    parameter int unsigned CTRL_OFS  = 0,
    parameter int unsigned KICK_OFS  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [frac_clken_pkg::BUS_W-1:0]  bus_wdata,
    output logic [frac_clken_pkg::BUS_W-1:0]  bus_rdata,
    output logic                              rate_busy,
    output logic                              clk_en
);
    import frac_clken_pkg::*;

    localparam int unsigned FRAME = 1 << ACC_W;

    logic [ACC_W-1:0] shadow_code;
    logic [ACC_W-1:0] active_code;
    logic [ACC_W-1:0] frame_cnt;
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   mult;
    logic             pending;
    logic             commit;

    frac_clken_regs #(
        .ACC_W(ACC_W), .ADDR_W(ADDR_W), .FIELD_LSB(FIELD_LSB),
        .KICK_BIT(KICK_BIT), .CTRL_OFS(CTRL_OFS), .KICK_OFS(KICK_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .commit(commit), .shadow_code(shadow_code),
        .pending(pending), .bus_rdata(bus_rdata)
    );

    frac_clken_frame #(.ACC_W(ACC_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .pending(pending), .shadow_code(shadow_code),
        .frame_cnt(frame_cnt), .commit(commit), .active_code(active_code)
    );

    // Inverted code to multiplier.
    always_comb begin
        mult = (ACC_W+1)'(code_to_mult(int'(active_code), ACC_W));
    end

    frac_clken_phase #(.ACC_W(ACC_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .mult(mult), .acc(acc), .strobe(clk_en)
    );

    // Busy mirrors the pending commit.
    always_comb begin
        rate_busy = pending;
    end

    localparam int unsigned UNUSED_FRAME = FRAME;
endmodule

// File: rtl/frac_clken_chk.sv
// Module: assertion checker bound into the top module.
module frac_clken_chk #(
    parameter int unsigned ACC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pending,
    input logic [ACC_W-1:0] frame_cnt,
    input logic [ACC_W-1:0] shadow_code,
    input logic [ACC_W-1:0] active_code,
    input logic [ACC_W-1:0] acc
);
    localparam int unsigned FRAME = 1 << ACC_W;
    int unsigned wait_cnt;

    // Count cycles a commit has been pending.
    always_ff @(posedge clk) begin
        if (!rst_n || !pending) wait_cnt <= 0;
        else                    wait_cnt <= wait_cnt + 1;
    end

    // R5
    kick_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= FRAME + 1);
    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(shadow_code));
    // R9
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> frame_cnt == '0);
    // R9
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != '0) |-> $stable(active_code));
    // R9
    phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt == '0) |-> acc == '0);
endmodule

bind frac_clken_gen frac_clken_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pending(pending), .frame_cnt(frame_cnt),
    .shadow_code(shadow_code), .active_code(active_code), .acc(acc)
);

// File: tb/frac_clken_gen_tb.sv
module frac_clken_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rate_busy;
    logic        clk_en;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    frac_clken_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rate_busy(rate_busy), .clk_en(clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_en) cnt++;
        end
    endtask

    // Poll for commit-bit clear; returns cycles since write edge.
    task automatic wait_commit(output int cyc);
        logic [31:0] d;
        cyc = 1;
        for (int i = 0; i < 60; i++) begin
            bus_read(4'h4, d);
            if (!d[31]) break;
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    task automatic commit_rate(input int code, input string req);
        int cyc;
        bus_write(4'h0, 32'(code) << 8);
        bus_write(4'h4, 32'h8000_0000);
        wait_commit(cyc);
        check({req, " R5 commit latency ok"}, int'(cyc <= 34), 1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        int cnt;
        @(negedge clk);
        bus_read(4'h0, d); check("R1 code at reset", int'(d), 0);
        bus_read(4'h4, d); check("R1 commit bit at reset", int'(d), 0);
        check("R1 busy at reset", int'(rate_busy), 0);
        check("R1 clk_en at reset", int'(clk_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        count_pulses(32, cnt);
        check("R1 full rate after reset", cnt, 32);
    endtask

    task automatic t_field_only();
        logic [31:0] d;
        int cnt;
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, d);
        check("R2 only bits 12:8 written", int'(d), 32'h0000_1F00);
        count_pulses(32, cnt);
        check("R3 rate unchanged without commit", cnt, 32);
        bus_write(4'h4, 32'h7FFF_FFFF);
        bus_read(4'h4, d);
        check("R4 write with bit31 low ignored", int'(d), 0);
        count_pulses(32, cnt);
        check("R3 rate still unchanged", cnt, 32);
    endtask

    task automatic t_kick();
        logic [31:0] d;
        int cyc, cnt;
        bus_write(4'h4, 32'h8000_0000);
        bus_read(4'h4, d);
        check("R4 commit bit reads set", int'(d[31]), 1);
        check("R4 busy while pending", int'(rate_busy), 1);
        wait_commit(cyc);
        check("R5 cleared within 34 cycles", int'(cyc <= 34), 1);
        check("R4 busy low after commit", int'(rate_busy), 0);
        count_pulses(32, cnt);
        check("R6 code 31 gives 1 strobe", cnt, 1);
    endtask

    task automatic t_rates();
        int cnt;
        commit_rate(16, "R6");
        count_pulses(32, cnt);
        check("R6 code 16 gives 16 strobes", cnt, 16);
        count_pulses(32, cnt);
        check("R6 code 16 second window", cnt, 16);
        commit_rate(0, "R6");
        count_pulses(32, cnt);
        check("R6 code 0 gives 32 strobes", cnt, 32);
    endtask

    task automatic t_blocked_and_spread();
        logic [31:0] d;
        int cyc, cnt, last, gap_bad;
        bus_write(4'h0, 32'(27) << 8);
        bus_write(4'h4, 32'h8000_0000);
        bus_write(4'h0, 32'(3) << 8);
        bus_read(4'h0, d);
        check("R7 code write ignored while pending", int'(d[12:8]), 27);
        wait_commit(cyc);
        check("R5 cleared within 34 cycles", int'(cyc <= 34), 1);
        count_pulses(32, cnt);
        check("R7 old code applied, 5 strobes", cnt, 5);
        last = -1; gap_bad = 0; cnt = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (clk_en) begin
                if (last >= 0 && (i - last < 6 || i - last > 7)) gap_bad++;
                last = i; cnt++;
            end
        end
        check("R8 gaps of 6 or 7 cycles", gap_bad, 0);
        check("R8 strobes over 64 cycles", cnt, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_field_only();
        t_kick();
        t_rates();
        t_blocked_and_spread();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule